// File: doc/BRIEF.md
# Return-Address Stack Cache with Hysteretic Spill and Fill

This block keeps the newest part of a hardware return-address stack in a small on-chip ring of registers. The core pushes a return address on every call and pops one on every return through a valid/ready handshake. When the ring gets crowded, the oldest entries are written out to main memory. When it runs low, those entries are read back. Both directions use hysteresis, so the memory traffic comes in short bursts and is not repeated on every call or return.

Memory traffic goes through one request/grant port with a single transaction in flight. Ordinary spill and fill requests wait for cycles on which the shared bus is idle. When the ring is completely full, a spill request goes out at once and is flagged urgent. When the ring is empty, a fill request does the same. The stack grows downward with pre-decrement, and all addresses count in 16-bit words. A configuration strobe loads two hard bounds. The stack base is the address just above the oldest entry. The stack limit is the lowest address an entry may take. A push that would go below the limit and a pop at the base are refused, and each raises a one-cycle exception pulse.

Top module: `ret_stack_cache`

## Requirements
- R1: Each accepted pop returns the most recently pushed value that has not yet been popped. This also holds for entries that made a round trip through memory. The occupancy output counts the entries held in the ring.
- R2: Pushes that leave the ring at 12 entries or fewer never start a memory write. A push accepted while the ring already holds 12 or more entries arms spilling.
- R3: Once armed, spilling writes the oldest entries out until occupancy is back to 8. An accepted pop disarms spilling, and no write is requested after that pop.
- R4: A request with mem_urgent_o low is raised only while mem_busy_i is low. If the ring holds 16 entries with spilling armed, or holds 0 entries while memory still holds part of the stack, the request is raised with mem_urgent_o high, regardless of mem_busy_i.
- R5: When memory holds entries, an accepted pop made with 5 or fewer entries in the ring arms filling. So does a pop attempted on an empty ring. Filling reads entries back until occupancy reaches 8 or memory holds none, and an accepted push disarms it.
- R6: A spill writes the oldest cached entry to address cache_lim_o-1, and cache_lim_o then drops by one. A fill reads from address cache_lim_o, which then rises by one. The stack base minus cache_lim_o is the number of entries held in memory.
- R7: push_ready_o is low while the ring is full or a fill read is pending that would fill it. pop_ready_o is low while the ring is empty and memory still holds entries.
- R8: A push presented while sp_o equals the stack limit is accepted without effect: sp_o and the occupancy do not change. ovf_o is high in the following cycle only.
- R9: A pop presented while sp_o equals the stack base is accepted without effect, and pop_data_o reads zero. unf_o is high in the following cycle only.
- R10: After reset the occupancy is 0 and no request is raised. cfg_load_i loads both bounds, sets sp_o and cache_lim_o to the new base, and empties the ring.
- R11: When push_valid_i and pop_valid_i are both high, the push is served and pop_ready_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_load_i | input | 1 | Load the stack bounds and empty the stack |
| cfg_base_i | input | AW | Stack base: the address just above the oldest entry |
| cfg_limit_i | input | AW | Stack limit: the lowest address an entry may take |
| push_valid_i | input | 1 | Push request |
| push_data_i | input | DW | Return address to push |
| push_ready_o | output | 1 | Push accepted on this cycle |
| pop_valid_i | input | 1 | Pop request |
| pop_ready_o | output | 1 | Pop accepted on this cycle; pop_data_o is valid |
| pop_data_o | output | DW | Popped return address |
| ovf_o | output | 1 | Overflow exception pulse |
| unf_o | output | 1 | Underflow exception pulse |
| mem_req_o | output | 1 | Memory request |
| mem_urgent_o | output | 1 | Request takes priority over other bus users |
| mem_we_o | output | 1 | 1 for a spill write, 0 for a fill read |
| mem_addr_o | output | AW | Word address of the request |
| mem_wdata_o | output | DW | Spill write data |
| mem_busy_i | input | 1 | Bus taken by fetch, data or DMA traffic |
| mem_gnt_i | input | 1 | Request accepted on this cycle |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | DW | Read data |
| sp_o | output | AW | Logical stack pointer, which is also the cache base |
| cache_lim_o | output | AW | Address just above the cached window |
| occ_o | output | $clog2(DEPTH+1) | Entries held in the ring |

## Verification
The hardest states to reach are the ones where priority escalates. The ring has to be full with spilling armed, or empty while memory holds part of the stack, and in both cases the bus has to be reported busy. The bench holds mem_busy_i high and pushes twenty entries against a tight limit, so every full-ring write must go out as urgent. It then pops the stack down to its base, so the last entries can only come back through urgent reads. The chance for a pop to cancel a spill lasts only one cycle. To reach it, the bench withholds grants while spilling is armed, pops, and then releases the grant.

// File: rtl/rss_pkg.sv
package rss_pkg;
  typedef enum logic [1:0] {
    MOP_IDLE  = 2'd0,
    MOP_SPILL = 2'd1,
    MOP_FILL  = 2'd2
  } mop_e;
endpackage

// File: rtl/rss_ring.sv
module rss_ring #(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  localparam int IW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  input  logic          ins_i,
  input  logic [DW-1:0] ins_data_i,
  input  logic          del_i,
  output logic [DW-1:0] top_o,
  output logic [DW-1:0] old_o,
  output logic [CW-1:0] occ_o,
  output logic [CW-1:0] occ_nx_o
);
  logic [DW-1:0] slot_q [DEPTH];
  logic [IW-1:0] tp_q;
  logic [CW-1:0] occ_q;
  logic [IW-1:0] occ_lo, old_idx, ins_idx, push_idx;

  assign occ_lo   = occ_q[IW-1:0];
  assign old_idx  = tp_q + occ_lo - IW'(1);
  assign ins_idx  = tp_q + occ_lo;
  assign push_idx = tp_q - IW'(1);
  assign occ_nx_o = occ_q + CW'(ins_i) + CW'(push_i) - CW'(pop_i) - CW'(del_i);
  assign top_o    = slot_q[tp_q];
  assign old_o    = slot_q[old_idx];
  assign occ_o    = occ_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tp_q  <= '0;
      occ_q <= '0;
    end else if (clr_i) begin
      tp_q  <= '0;
      occ_q <= '0;
    end else begin
      if (push_i)     tp_q <= push_idx;
      else if (pop_i) tp_q <= tp_q + IW'(1);
      occ_q <= occ_nx_o;
    end
  end

  // push slot and refill slot never coincide: a refill needs room for one more
  always_ff @(posedge clk_i) begin
    if (push_i && !clr_i) slot_q[push_idx] <= push_data_i;
    if (ins_i && !clr_i)  slot_q[ins_idx]  <= ins_data_i;
  end
endmodule

// File: rtl/rss_memport.sv
module rss_memport
  import rss_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  mop_e          op_i,
  input  logic          urgent_i,
  input  logic [AW-1:0] lim_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          busy_i,
  input  logic          gnt_i,
  input  logic          rvalid_i,
  output logic          req_o,
  output logic          urgent_o,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic          wr_done_o,
  output logic          rd_issue_o,
  output logic          rd_done_o,
  output logic          rd_pend_o
);
  logic rd_pend_q;
  mop_e op_eff;

  // one transaction in flight: hold off new requests while a read is pending
  assign op_eff     = rd_pend_q ? MOP_IDLE : op_i;
  assign urgent_o   = urgent_i && (op_eff != MOP_IDLE);
  assign req_o      = (op_eff != MOP_IDLE) && (!busy_i || urgent_o);
  assign we_o       = (op_eff == MOP_SPILL);
  assign addr_o     = we_o ? lim_i - AW'(1) : lim_i;
  assign wdata_o    = wdata_i;
  assign wr_done_o  = req_o && we_o && gnt_i;
  assign rd_issue_o = req_o && !we_o && gnt_i;
  assign rd_done_o  = rd_pend_q && rvalid_i;
  assign rd_pend_o  = rd_pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         rd_pend_q <= 1'b0;
    else if (clr_i)      rd_pend_q <= 1'b0;
    else if (rd_issue_o) rd_pend_q <= 1'b1;
    else if (rd_done_o)  rd_pend_q <= 1'b0;
  end
endmodule

// File: rtl/ret_stack_cache.sv
module ret_stack_cache
  import rss_pkg::*;
#(
  parameter int AW       = 16,
  parameter int DW       = 16,
  parameter int DEPTH    = 16,
  parameter int SPILL_HI = 12,
  parameter int SPILL_LO = 8,
  parameter int FILL_LO  = 4,
  localparam int CW      = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_load_i,
  input  logic [AW-1:0] cfg_base_i,
  input  logic [AW-1:0] cfg_limit_i,
  input  logic          push_valid_i,
  input  logic [DW-1:0] push_data_i,
  output logic          push_ready_o,
  input  logic          pop_valid_i,
  output logic          pop_ready_o,
  output logic [DW-1:0] pop_data_o,
  output logic          ovf_o,
  output logic          unf_o,
  output logic          mem_req_o,
  output logic          mem_urgent_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_busy_i,
  input  logic          mem_gnt_i,
  input  logic          mem_rvalid_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [AW-1:0] sp_o,
  output logic [AW-1:0] cache_lim_o,
  output logic [CW-1:0] occ_o
);
  logic [AW-1:0] base_q, lim_q, sp_q, clim_q, clim_nx;
  logic          spill_q, fill_q, ovf_q, unf_q;
  logic          spill_nx, fill_nx, fill_set;
  logic [CW-1:0] occ, occ_nx;
  logic [DW-1:0] top_w, old_w;
  logic          at_lim, at_base, has_ram, room;
  logic          push_fire, push_ovf, pop_sel, pop_fire, pop_unf;
  logic          wr_done, rd_issue, rd_done, rd_pend, urgent;
  mop_e          op;

  assign at_lim  = (sp_q == lim_q);
  assign at_base = (sp_q == base_q);
  assign has_ram = (clim_q != base_q);
  assign room    = (int'(occ) + int'(rd_pend)) < DEPTH;

  assign push_ovf  = push_valid_i && at_lim && !cfg_load_i;
  assign push_fire = push_valid_i && !at_lim && room && !cfg_load_i;
  assign pop_sel   = pop_valid_i && !push_valid_i && !cfg_load_i;
  assign pop_unf   = pop_sel && at_base;
  assign pop_fire  = pop_sel && !at_base && (occ != '0);

  assign push_ready_o = at_lim || room;
  assign pop_ready_o  = !push_valid_i && (at_base || (occ != '0));
  assign pop_data_o   = at_base ? '0 : top_w;

  assign op     = spill_q ? MOP_SPILL : ((fill_q && has_ram) ? MOP_FILL : MOP_IDLE);
  assign urgent = spill_q ? (int'(occ) == DEPTH) : (occ == '0);

  rss_ring #(.DW(DW), .DEPTH(DEPTH)) u_ring (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (cfg_load_i),
    .push_i      (push_fire),
    .push_data_i (push_data_i),
    .pop_i       (pop_fire),
    .ins_i       (rd_done),
    .ins_data_i  (mem_rdata_i),
    .del_i       (wr_done),
    .top_o       (top_w),
    .old_o       (old_w),
    .occ_o       (occ),
    .occ_nx_o    (occ_nx)
  );

  rss_memport #(.AW(AW), .DW(DW)) u_port (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (cfg_load_i),
    .op_i       (op),
    .urgent_i   (urgent),
    .lim_i      (clim_q),
    .wdata_i    (old_w),
    .busy_i     (mem_busy_i),
    .gnt_i      (mem_gnt_i),
    .rvalid_i   (mem_rvalid_i),
    .req_o      (mem_req_o),
    .urgent_o   (mem_urgent_o),
    .we_o       (mem_we_o),
    .addr_o     (mem_addr_o),
    .wdata_o    (mem_wdata_o),
    .wr_done_o  (wr_done),
    .rd_issue_o (rd_issue),
    .rd_done_o  (rd_done),
    .rd_pend_o  (rd_pend)
  );

  assign clim_nx  = clim_q - AW'(wr_done) + AW'(rd_issue);
  assign fill_set = has_ram && ((pop_fire && int'(occ) <= FILL_LO + 1) ||
                                (pop_sel && occ == '0 && !at_base));
  // hysteresis: arm on the high or low mark, run to the half mark, opposite op cancels
  assign spill_nx = (spill_q || (push_fire && int'(occ) >= SPILL_HI)) &&
                    !pop_fire && int'(occ_nx) > SPILL_LO;
  assign fill_nx  = (fill_q || fill_set) && !push_fire &&
                    (clim_nx != base_q) && int'(occ_nx) < SPILL_LO;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= '0;
      lim_q   <= '0;
      sp_q    <= '0;
      clim_q  <= '0;
      spill_q <= 1'b0;
      fill_q  <= 1'b0;
      ovf_q   <= 1'b0;
      unf_q   <= 1'b0;
    end else if (cfg_load_i) begin
      base_q  <= cfg_base_i;
      lim_q   <= cfg_limit_i;
      sp_q    <= cfg_base_i;
      clim_q  <= cfg_base_i;
      spill_q <= 1'b0;
      fill_q  <= 1'b0;
      ovf_q   <= 1'b0;
      unf_q   <= 1'b0;
    end else begin
      if (push_fire)     sp_q <= sp_q - AW'(1);
      else if (pop_fire) sp_q <= sp_q + AW'(1);
      clim_q  <= clim_nx;
      spill_q <= spill_nx;
      fill_q  <= fill_nx;
      ovf_q   <= push_ovf;
      unf_q   <= pop_unf;
    end
  end

  assign ovf_o       = ovf_q;
  assign unf_o       = unf_q;
  assign sp_o        = sp_q;
  assign cache_lim_o = clim_q;
  assign occ_o       = occ;
endmodule

// File: rtl/rss_chk.sv
module rss_chk #(
  parameter int AW       = 16,
  parameter int DEPTH    = 16,
  parameter int SPILL_LO = 8,
  parameter int CW       = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cfg_load_i,
  input logic          push_valid_i,
  input logic          push_ready_o,
  input logic          pop_valid_i,
  input logic          ovf_o,
  input logic          unf_o,
  input logic          mem_req_o,
  input logic          mem_urgent_o,
  input logic          mem_we_o,
  input logic          mem_busy_i,
  input logic [AW-1:0] mem_addr_o,
  input logic [AW-1:0] sp_o,
  input logic [AW-1:0] cache_lim_o,
  input logic [CW-1:0] occ_o,
  input logic [AW-1:0] base_q,
  input logic [AW-1:0] lim_q,
  input logic          rd_pend
);
  a_r4_idle_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_urgent_o) |-> !mem_busy_i);

  a_r6_spill_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> (mem_addr_o == cache_lim_o - AW'(1)));

  a_r6_fill_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |-> (mem_addr_o == cache_lim_o));

  a_r3_spill_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> (int'(occ_o) > SPILL_LO));

  a_r7_full_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(occ_o) == DEPTH && sp_o != lim_q) |-> !push_ready_o);

  a_r8_ovf_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_valid_i && sp_o == lim_q && !cfg_load_i) |=> (ovf_o && sp_o == $past(sp_o)));

  a_r9_unf_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_valid_i && !push_valid_i && !cfg_load_i && sp_o == base_q) |=> unf_o);

  a_r1_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cache_lim_o - sp_o) == (AW'(occ_o) + AW'(rd_pend)));

  a_r10_occ_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(occ_o) <= DEPTH);
endmodule

bind ret_stack_cache rss_chk #(
  .AW(AW), .DEPTH(DEPTH), .SPILL_LO(SPILL_LO), .CW(CW)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cfg_load_i   (cfg_load_i),
  .push_valid_i (push_valid_i),
  .push_ready_o (push_ready_o),
  .pop_valid_i  (pop_valid_i),
  .ovf_o        (ovf_o),
  .unf_o        (unf_o),
  .mem_req_o    (mem_req_o),
  .mem_urgent_o (mem_urgent_o),
  .mem_we_o     (mem_we_o),
  .mem_busy_i   (mem_busy_i),
  .mem_addr_o   (mem_addr_o),
  .sp_o         (sp_o),
  .cache_lim_o  (cache_lim_o),
  .occ_o        (occ_o),
  .base_q       (base_q),
  .lim_q        (lim_q),
  .rd_pend      (rd_pend)
);

// File: tb/ret_stack_cache_bench.sv
module ret_stack_cache_bench;
  localparam int AW = 16, DW = 16, CW = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          cfg_load = 0;
  logic [AW-1:0] cfg_base = '0, cfg_limit = '0;
  logic          push_valid = 0, pop_valid = 0;
  logic [DW-1:0] push_data = '0;
  logic          push_ready, pop_ready, ovf, unf;
  logic [DW-1:0] pop_data;
  logic          req, urg, we, gnt, rvalid;
  logic [AW-1:0] addr, sp, clim;
  logic [DW-1:0] wdata, rdata;
  logic [CW-1:0] occ;
  logic          busy = 0, gnt_hold = 0;

  assign gnt = req && !gnt_hold;

  ret_stack_cache u_ret_stack_cache (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_load_i(cfg_load), .cfg_base_i(cfg_base), .cfg_limit_i(cfg_limit),
    .push_valid_i(push_valid), .push_data_i(push_data), .push_ready_o(push_ready),
    .pop_valid_i(pop_valid), .pop_ready_o(pop_ready), .pop_data_o(pop_data),
    .ovf_o(ovf), .unf_o(unf),
    .mem_req_o(req), .mem_urgent_o(urg), .mem_we_o(we), .mem_addr_o(addr),
    .mem_wdata_o(wdata), .mem_busy_i(busy), .mem_gnt_i(gnt),
    .mem_rvalid_i(rvalid), .mem_rdata_i(rdata),
    .sp_o(sp), .cache_lim_o(clim), .occ_o(occ)
  );

  // memory model: writes land at grant, read data two edges after grant
  logic [DW-1:0] ram [256];
  logic          rd_s1;
  logic [7:0]    rd_a;
  int n_wr = 0, n_rd = 0, n_urg = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_s1 <= 0; rvalid <= 0; rdata <= '0; rd_a <= '0;
    end else begin
      rvalid <= rd_s1;
      rdata  <= ram[rd_a];
      rd_s1  <= req && gnt && !we;
      if (req && gnt) begin
        rd_a <= addr[7:0];
        if (we) begin ram[addr[7:0]] <= wdata; n_wr <= n_wr + 1; end
        else n_rd <= n_rd + 1;
        if (busy) n_urg <= n_urg + 1;
      end
    end
  end

  int tests = 0, fails = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_push(input logic [DW-1:0] d, output logic o);
    @(negedge clk);
    push_valid = 1; push_data = d;
    #1;
    while (!push_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    push_valid = 0;
    #1 o = ovf;
  endtask

  task automatic do_pop(output logic [DW-1:0] d, output logic u);
    @(negedge clk);
    pop_valid = 1;
    #1;
    while (!pop_ready) begin @(negedge clk); #1; end
    d = pop_data;
    @(negedge clk);
    pop_valid = 0;
    #1 u = unf;
  endtask

  task automatic load(input logic [AW-1:0] b, input logic [AW-1:0] l);
    @(negedge clk);
    cfg_load = 1; cfg_base = b; cfg_limit = l;
    @(negedge clk);
    cfg_load = 0;
  endtask

  // {push, data (push value or expected pop value), expected occupancy}
  localparam logic [24:0] VEC [8] = '{
    {1'b1, 16'h1111, 8'd1}, {1'b1, 16'h2222, 8'd2}, {1'b1, 16'h3333, 8'd3},
    {1'b0, 16'h3333, 8'd2}, {1'b1, 16'h4444, 8'd3}, {1'b0, 16'h4444, 8'd2},
    {1'b0, 16'h2222, 8'd1}, {1'b0, 16'h1111, 8'd0}
  };

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic o, u;
    logic [DW-1:0] d;
    int w0, r0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    check(occ == 0, "R10 reset occupancy", occ, 0);
    check(req == 0, "R10 reset request", req, 0);

    load(16'd200, 16'd180);
    #1;
    check(sp == 16'd200, "R10 load sp", sp, 200);
    check(clim == 16'd200, "R10 load cache limit", clim, 200);

    // vector table, bus busy so nothing leaves the ring
    busy = 1;
    for (int i = 0; i < 8; i++) begin
      if (VEC[i][24]) do_push(VEC[i][23:8], o);
      else begin
        do_pop(d, u);
        check(d == VEC[i][23:8], "R1 table pop", d, VEC[i][23:8]);
      end
      check(occ == VEC[i][7:0], "R1 table occupancy", occ, VEC[i][7:0]);
    end

    // busy bus: only urgent spills, then a hard overflow
    for (int i = 1; i <= 20; i++) begin
      do_push(16'hA000 + 16'(i), o);
      if (i == 16) check(push_ready == 0, "R7 full ring stalls push", push_ready, 0);
    end
    wait_cyc(5); #1;
    check(occ == 15, "R4 urgent spill occupancy", occ, 15);
    check(n_wr == 5, "R4 urgent writes", n_wr, 5);
    check(n_urg >= 5, "R4 grants while busy", n_urg, 5);
    check(ram[199] == 16'hA001, "R6 oldest at base-1", ram[199], 16'hA001);
    check(clim == 16'd195, "R6 cache limit after spill", clim, 195);
    do_push(16'hDEAD, o);
    check(o == 1, "R8 overflow pulse", o, 1);
    check(sp == 16'd180, "R8 sp unchanged", sp, 180);
    check(occ == 15, "R8 occupancy unchanged", occ, 15);
    @(negedge clk); #1;
    check(ovf == 0, "R8 pulse one cycle", ovf, 0);

    for (int k = 0; k < 15; k++) begin
      do_pop(d, u);
      check(d == 16'hA000 + 16'(20 - k), "R1 pop order", d, 16'hA000 + 16'(20 - k));
    end
    check(pop_ready == 0, "R7 empty ring stalls pop", pop_ready, 0);
    for (int k = 15; k < 20; k++) begin
      do_pop(d, u);
      check(d == 16'hA000 + 16'(20 - k), "R5 urgent refill order", d, 16'hA000 + 16'(20 - k));
    end
    do_pop(d, u);
    check(u == 1, "R9 underflow pulse", u, 1);
    check(d == 0, "R9 pop data zero", d, 0);
    check(sp == 16'd200, "R9 sp at base", sp, 200);
    @(negedge clk); #1;
    check(unf == 0, "R9 pulse one cycle", unf, 0);

    // idle bus: hysteresis in both directions
    busy = 0;
    load(16'd100, 16'd60);
    w0 = n_wr; r0 = n_rd;
    for (int i = 1; i <= 12; i++) do_push(16'hB000 + 16'(i), o);
    wait_cyc(8); #1;
    check(occ == 12, "R2 no spill at 12", occ, 12);
    check(n_wr == w0, "R2 no write at 12", n_wr - w0, 0);
    do_push(16'hB00D, o);
    wait_cyc(10); #1;
    check(occ == 8, "R3 spill stops at 8", occ, 8);
    check(n_wr - w0 == 5, "R3 spill write count", n_wr - w0, 5);
    check(ram[99] == 16'hB001 && ram[95] == 16'hB005, "R6 spill placement", ram[95], 16'hB005);
    check(clim == 16'd95, "R6 cache limit", clim, 95);
    for (int k = 0; k < 4; k++) begin
      do_pop(d, u);
      check(d == 16'hB00D - 16'(k), "R1 pop before fill", d, 16'hB00D - 16'(k));
    end
    wait_cyc(15); #1;
    check(occ == 8, "R5 fill back to 8", occ, 8);
    check(n_rd - r0 == 4, "R5 fill read count", n_rd - r0, 4);
    check(clim == 16'd99, "R6 cache limit after fill", clim, 99);
    for (int k = 0; k < 9; k++) begin
      do_pop(d, u);
      check(d == 16'hB009 - 16'(k), "R1 pop after fill", d, 16'hB009 - 16'(k));
    end

    // cancel a spill with a pop while grants are withheld
    load(16'd100, 16'd60);
    gnt_hold = 1;
    w0 = n_wr;
    for (int i = 1; i <= 13; i++) do_push(16'hC000 + 16'(i), o);
    wait_cyc(2); #1;
    check(req == 1 && we == 1, "R3 spill armed", req, 1);
    do_pop(d, u);
    check(d == 16'hC00D, "R1 pop during spill", d, 16'hC00D);
    check(req == 0, "R3 pop cancels spill", req, 0);
    gnt_hold = 0;
    wait_cyc(10); #1;
    check(n_wr == w0 && occ == 12, "R3 no write after cancel", n_wr - w0, 0);

    busy = 1;
    do_push(16'hC0EE, o);
    wait_cyc(3); #1;
    check(req == 0, "R4 busy blocks ordinary spill", req, 0);
    check(occ == 13, "R2 occupancy 13 while busy", occ, 13);
    busy = 0;
    wait_cyc(10); #1;
    check(occ == 8, "R3 spill after bus frees", occ, 8);

    // simultaneous push and pop: push wins
    @(negedge clk);
    push_valid = 1; push_data = 16'hD0D0; pop_valid = 1;
    #1;
    check(pop_ready == 0, "R11 pop held off by push", pop_ready, 0);
    @(negedge clk);
    push_valid = 0; pop_valid = 0;
    #1;
    check(occ == 9, "R11 push served", occ, 9);
    do_pop(d, u);
    check(d == 16'hD0D0, "R11 pushed value on top", d, 16'hD0D0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule